// File: doc/BRIEF.md
# Status LED Pin Driver with Reset Strap Capture

This block owns one bidirectional pin that shows a network status on an LED. One of several status event inputs drives the LED. A configuration input picks which one. A short event is stretched by a programmable down-counter so that it stays visible. The light polarity can be programmed, and it also sets the driver type. When the LED lights on a low level, the pin works as open-drain: it pulls low to light and is released otherwise. When the LED lights on a high level, the pin actively drives both levels.

The same pin is a configuration strap. While reset is held, the pin is never driven and acts only as an input. The level seen on the last rising clock edge before reset is released decides whether a serial configuration memory is reported as fitted. The pad itself is modelled by separate input, output and output-enable signals.

The polarity and source selection are captured in registers on every clock edge. A change therefore takes effect one clock later. Reset sets these registers to the light-on-low polarity and to a source chosen by parameter.

Top module: `led_pin_ctrl`

## Requirements
- R1: While rst_n is low, pad_oe is 0 and pad_out is 0, whatever the other inputs are.
- R2: eedet holds the pad_in value sampled on the last rising clk edge at which rst_n was low (1 means memory present, 0 means absent). It stays unchanged while rst_n is high, whatever pad_in does.
- R3: After reset releases and before the next rising edge, the polarity is light-on-low (cfg_active_high reads as 0), the source is DEFAULT_SRC, and the LED is off, so pad_oe is 0.
- R4: With light-on-low polarity (cfg_active_high = 0), a lit LED gives pad_oe = 1 and pad_out = 0. An unlit LED gives pad_oe = 0.
- R5: With light-on-high polarity (cfg_active_high = 1), pad_oe is 1 and pad_out equals the lit state.
- R6: Only evt_in[index] lights the LED, where index is the registered cfg_src_sel. Events on the other bits have no effect on the pin.
- R7: A selected event sampled at rising edge k lights the LED from edge k for max(L,1) cycles. L is the stretch_len value at edge k. A level that is held keeps the LED lit.
- R8: A selected event that arrives while a stretch is counting down reloads the count to stretch_len.
- R9: A change on cfg_active_high or cfg_src_sel takes effect only after the next rising clk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pad_in | input | 1 | Level seen at the pin |
| cfg_active_high | input | 1 | 1 = LED lights on high, push-pull; 0 = lights on low, open-drain |
| cfg_src_sel | input | SEL_W | Index of the status event shown on the LED |
| evt_in | input | NUM_EVENTS | Status event inputs, one bit each |
| stretch_len | input | STRETCH_W | Minimum number of lit cycles after an event |
| pad_out | output | 1 | Value driven onto the pin |
| pad_oe | output | 1 | Pin driver enable |
| eedet | output | 1 | Strap result: configuration memory present |

## Verification
Two functions can act in the same clock edge. A configuration write can land on the edge where a selected event is sampled. It can also land while a stretch is still counting down. The bench provokes both cases: it switches polarity or source in the cycle an event arrives. It then checks that the event is judged against the old source and that the new drive mode shows only on the following edge, while the stretch count carries on. A second overlap occurs at reset release, where the strap sample and a pin change fall in the same cycle. The bench toggles pad_in right after release and checks that eedet keeps the last value sampled during reset.

// File: rtl/led_pin_pkg.sv
package led_pin_pkg;

  typedef enum logic {
    DRV_OPEN_DRAIN = 1'b0,
    DRV_PUSH_PULL  = 1'b1
  } drive_mode_e;

  function automatic drive_mode_e mode_from_cfg(input logic act_high);
    return act_high ? DRV_PUSH_PULL : DRV_OPEN_DRAIN;
  endfunction

endpackage

// File: rtl/led_strap_capture.sv
module led_strap_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic strap_o
);

  logic strap_q;
  logic strap_en;

  // follow the pin while reset is held, freeze on release
  assign strap_en = ~rst_n;

  always_ff @(posedge clk) begin
    if (strap_en) begin
      strap_q <= pin_i;
    end
  end

  assign strap_o = strap_q;

endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             lit_o
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             hit_q;
  logic             cnt_busy;

  assign cnt_busy = (cnt_q != '0);

  always_comb begin
    cnt_nxt = cnt_q;
    if (trig_i) begin
      cnt_nxt = len_i;
    end else if (cnt_busy) begin
      cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      hit_q <= trig_i;
    end
  end

  assign lit_o = hit_q | cnt_busy;

endmodule

// File: rtl/led_pad_drive.sv
module led_pad_drive
  import led_pin_pkg::*;
(
  input  logic        rst_n,
  input  drive_mode_e mode_i,
  input  logic        lit_i,
  output logic        pad_out,
  output logic        pad_oe
);

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    if (rst_n) begin
      unique case (mode_i)
        DRV_PUSH_PULL: begin
          pad_oe  = 1'b1;
          pad_out = lit_i;
        end
        DRV_OPEN_DRAIN: begin
          pad_oe  = lit_i;
          pad_out = 1'b0;
        end
        default: begin
          pad_oe  = 1'b0;
          pad_out = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/led_pin_ctrl.sv
module led_pin_ctrl
  import led_pin_pkg::*;
#(
  parameter int NUM_EVENTS  = 4,
  parameter int STRETCH_W   = 8,
  parameter int DEFAULT_SRC = 0,
  localparam int SEL_W      = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pad_in,
  input  logic                  cfg_active_high,
  input  logic [SEL_W-1:0]      cfg_src_sel,
  input  logic [NUM_EVENTS-1:0] evt_in,
  input  logic [STRETCH_W-1:0]  stretch_len,
  output logic                  pad_out,
  output logic                  pad_oe,
  output logic                  eedet
);

  logic             act_high_q, act_high_nxt;
  logic [SEL_W-1:0] src_q, src_nxt;
  logic             sel_evt;
  logic             lit;
  drive_mode_e      drv_mode;

  always_comb begin
    act_high_nxt = cfg_active_high;
    src_nxt      = cfg_src_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_high_q <= 1'b0;
      src_q      <= SEL_W'(DEFAULT_SRC);
    end else begin
      act_high_q <= act_high_nxt;
      src_q      <= src_nxt;
    end
  end

  always_comb begin
    sel_evt = 1'b0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (src_q == SEL_W'(i)) begin
        sel_evt = sel_evt | evt_in[i];
      end
    end
  end

  assign drv_mode = mode_from_cfg(act_high_q);

  led_strap_capture u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pad_in),
    .strap_o (eedet)
  );

  led_pulse_stretch #(
    .CNT_W (STRETCH_W)
  ) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (sel_evt),
    .len_i  (stretch_len),
    .lit_o  (lit)
  );

  led_pad_drive u_drive (
    .rst_n   (rst_n),
    .mode_i  (drv_mode),
    .lit_i   (lit),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

endmodule

// File: rtl/led_pin_ctrl_chk.sv
module led_pin_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pad_out,
  input logic pad_oe,
  input logic eedet,
  input logic act_high_q,
  input logic sel_evt,
  input logic lit
);

  // R1
  reset_release_pin_chk: assert property (@(posedge clk)
    !rst_n |-> (!pad_oe && !pad_out));

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(eedet));

  // R4
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_high_q && pad_oe) |-> !pad_out);

  // R5
  push_pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_high_q |-> (pad_oe && (pad_out == lit)));

  // R7
  event_lights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_evt |=> lit);

endmodule

bind led_pin_ctrl led_pin_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .eedet      (eedet),
  .act_high_q (act_high_q),
  .sel_evt    (sel_evt),
  .lit        (lit)
);

// File: tb/led_pin_ctrl_bench.sv
module led_pin_ctrl_bench;

  localparam int NE = 4;
  localparam int SW = 2;
  localparam int LW = 8;
  localparam int NV = 16;

  logic          clk;
  logic          rst_n;
  logic          pad_in;
  logic          cfg_active_high;
  logic [SW-1:0] cfg_src_sel;
  logic [NE-1:0] evt_in;
  logic [LW-1:0] stretch_len;
  logic          pad_out, pad_oe, eedet;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  led_pin_ctrl #(.NUM_EVENTS(NE), .STRETCH_W(LW), .DEFAULT_SRC(0)) u_led_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_active_high(cfg_active_high),
    .cfg_src_sel(cfg_src_sel), .evt_in(evt_in), .stretch_len(stretch_len),
    .pad_out(pad_out), .pad_oe(pad_oe), .eedet(eedet)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {pol, src, evt, len, exp_oe, exp_out}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'b0000, 8'd3, 1'b0, 1'b0}, // R4 idle released
    {1'b0, 2'd0, 4'b0001, 8'd3, 1'b1, 1'b0}, // R4 R7 lit, pulled low
    {1'b0, 2'd0, 4'b0000, 8'd3, 1'b1, 1'b0}, // R7 stretch
    {1'b0, 2'd0, 4'b0000, 8'd3, 1'b1, 1'b0}, // R7 stretch
    {1'b0, 2'd0, 4'b0000, 8'd3, 1'b0, 1'b0}, // R7 ends after L cycles
    {1'b0, 2'd0, 4'b0010, 8'd3, 1'b0, 1'b0}, // R6 unselected bit ignored
    {1'b1, 2'd1, 4'b0000, 8'd0, 1'b1, 1'b0}, // R5 push-pull drives low
    {1'b1, 2'd1, 4'b0010, 8'd0, 1'b1, 1'b1}, // R5 R7 L=0 still one cycle
    {1'b1, 2'd1, 4'b0000, 8'd0, 1'b1, 1'b0}, // R7 one cycle only
    {1'b1, 2'd2, 4'b0100, 8'd2, 1'b1, 1'b0}, // R9 old source judged
    {1'b1, 2'd2, 4'b0100, 8'd2, 1'b1, 1'b1}, // R9 new source active
    {1'b1, 2'd2, 4'b0000, 8'd2, 1'b1, 1'b1}, // R7 stretch
    {1'b1, 2'd2, 4'b0000, 8'd2, 1'b1, 1'b0}, // R7 end
    {1'b0, 2'd3, 4'b1000, 8'd1, 1'b0, 1'b0}, // R9 old source, new polarity
    {1'b0, 2'd3, 4'b1000, 8'd1, 1'b1, 1'b0}, // R4 R6 source 3 lit
    {1'b0, 2'd3, 4'b0000, 8'd1, 1'b0, 1'b0}  // R4 R7 off
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic last_val);
    rst_n = 1'b0;
    pad_in = ~last_val;
    step();
    chk("R1 oe", pad_oe, 1'b0);
    chk("R1 out", pad_out, 1'b0);
    pad_in = last_val;
    step();
    chk("R1 oe", pad_oe, 1'b0);
    rst_n = 1'b1;
    pad_in = ~last_val;
    #1;
    chk("R3 default released", pad_oe, 1'b0);
    chk("R2 strap", eedet, last_val);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pad_in = 1'b0;
    cfg_active_high = 1'b1;
    cfg_src_sel = '0;
    evt_in = '0;
    stretch_len = 8'd3;
    #1;
    chk("R1 oe", pad_oe, 1'b0);
    do_reset(1'b1);
    step();
    chk("R2 strap held", eedet, 1'b1);
    step();

    for (int v = 0; v < NV; v++) begin
      {cfg_active_high, cfg_src_sel, evt_in, stretch_len} = VEC[v][16:2];
      pad_in = v[0];
      step();
      chk($sformatf("vec%0d oe", v), pad_oe, VEC[v][1]);
      chk($sformatf("vec%0d out", v), pad_out, VEC[v][0]);
    end
    chk("R2 strap unaffected", eedet, 1'b1);

    // R8 retrigger during countdown, push-pull
    cfg_active_high = 1'b1; cfg_src_sel = 2'd1; evt_in = '0; stretch_len = 8'd3;
    step();
    evt_in = 4'b0010; step(); evt_in = '0;
    step(); step();
    chk("R8 still lit", pad_out, 1'b1);
    evt_in = 4'b0010; step(); evt_in = '0;
    step(); step();
    chk("R8 reloaded", pad_out, 1'b1);
    step();
    chk("R8 end", pad_out, 1'b0);

    // R9 polarity swap on the event edge
    cfg_active_high = 1'b0; evt_in = 4'b0010; stretch_len = 8'd2;
    step(); evt_in = '0;
    chk("R9 swapped after edge oe", pad_oe, 1'b1);
    chk("R9 swapped after edge out", pad_out, 1'b0);
    cfg_active_high = 1'b1;
    #2;
    chk("R9 no early swap", pad_out, 1'b0);
    step();
    chk("R9 push-pull lit", pad_out, 1'b1);

    // R1 R2 second reset with strap low
    evt_in = '1;
    do_reset(1'b0);
    step();
    chk("R2 strap low held", eedet, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule